// File: doc/BRIEF.md
# Delayed Request Discard Timer

This block keeps one discard timer for each entry of a small delayed-transaction buffer in a bus bridge. Buffer control pulses a slot's start input once the upstream link has finished the first subrequests of an inbound delayed transaction. From then on, the slot counts secondary-bus clocks, which arrive as a clock-enable tick. If the original requester comes back with the same request, a retry-hit input stops the timer. If free is asserted instead, the slot is released. If neither happens in time, the slot expires and raises a drop level, which tells the buffer to discard that entry.

A control bit picks one of two power-of-two timeout lengths. Every discard sets a sticky status bit that software clears by writing a one. If error reporting is enabled, a discard also produces a one-cycle pulse on either the fatal or the non-fatal error output, as the severity bit selects. A synchronous warm reset returns every slot to idle and drops any pending error pulse, but the status bit keeps its value. Only the asynchronous cold reset clears the status bit.

Top module: `drt_discard_timer`

## Requirements
- R1: A start pulse on an idle slot arms it with a count of zero. An armed slot advances its count only on cycles where tick_i is 1. The clock edge that samples start does not count.
- R2: With short_sel_i = 1, an armed slot that receives no hit or free expires on the edge of its 2^SHORT_LOG2-th counted tick, and not before.
- R3: With short_sel_i = 0 (the reset value of the control), the expiry comes on the 2^LONG_LOG2-th counted tick.
- R4: A retry hit returns an armed slot to idle, and no discard is recorded. This includes a hit on the same tick that would have expired the slot.
- R5: A free pulse returns a slot to idle from the armed or the expired state. A freed slot does not expire later.
- R6: An expired slot holds drop_o[slot] = 1 and busy_o[slot] = 0 until it is freed.
- R7: A discard sets status_o, which then holds. A write with status_wr_i = 1 and status_wdata_i = 1 clears it. A write with data 0 has no effect. When a discard and a clearing write fall on the same edge, the discard wins.
- R8: When err_en_i = 1, a discard produces a one-cycle pulse on fatal_err_o if fatal_sel_i = 1, or on nonfatal_err_o if fatal_sel_i = 0. When err_en_i = 0, neither output pulses.
- R9: Discards in several slots on the same edge produce exactly one error pulse.
- R10: warm_rst_i = 1 returns every slot to idle and clears the error outputs. status_o keeps its value.
- R11: After cold reset (rst_ni low), every output is 0.
- R12: A start pulse on a slot that is already armed is ignored, and its count continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset; does not touch status |
| tick_i | input | 1 | Secondary-bus clock enable |
| short_sel_i | input | 1 | 1 selects the short timeout, 0 the long one |
| err_en_i | input | 1 | Enables error pulses on discard |
| fatal_sel_i | input | 1 | 1 routes the error to fatal, 0 to non-fatal |
| status_wr_i | input | 1 | Write strobe for the status bit |
| status_wdata_i | input | 1 | Write data; 1 clears the status bit |
| start_i | input | NUM_SLOTS | Per-slot arm pulse |
| hit_i | input | NUM_SLOTS | Per-slot retry hit |
| free_i | input | NUM_SLOTS | Per-slot release |
| busy_o | output | NUM_SLOTS | Slot is armed and counting |
| drop_o | output | NUM_SLOTS | Slot has expired; its entry should be discarded |
| status_o | output | 1 | Sticky discard flag |
| fatal_err_o | output | 1 | One-cycle fatal error pulse |
| nonfatal_err_o | output | 1 | One-cycle non-fatal error pulse |

## Verification
The bench samples the exact expiry edge at both timeout lengths. A design with an off-by-one count would show drop_o one tick early or one tick late. It also lands a retry hit on the expiring tick, where a design with the wrong priority would record a discard, and it lands a clearing write on the same edge as a discard, where a design with the wrong priority would lose the status bit. Further checks re-pulse start partway through a count (a design that restarts would expire late), gate the tick off for a long stretch, expire two slots together (a per-slot pulse would smear or double), and apply warm reset with status set (a design that also clears status would be caught).

// File: rtl/drt_pkg.sv
package drt_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE    = 2'd0,
    SLOT_ARMED   = 2'd1,
    SLOT_EXPIRED = 2'd2
  } slot_state_e;
endpackage

// File: rtl/drt_slot_timer.sv
module drt_slot_timer
  import drt_pkg::*;
#(
  parameter int LONG_LOG2  = 15,
  parameter int SHORT_LOG2 = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warm_rst_i,
  input  logic tick_i,
  input  logic short_sel_i,
  input  logic start_i,
  input  logic hit_i,
  input  logic free_i,
  output logic busy_o,
  output logic drop_o,
  output logic expire_o
);
  localparam int CNT_W = LONG_LOG2;
  localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SHORT_LAST = LONG_LAST >> (LONG_LOG2 - SHORT_LOG2);

  slot_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  logic             release_req;

  assign last        = short_sel_i ? SHORT_LAST : LONG_LAST;
  assign release_req = hit_i | free_i;
  // >= so a select change mid-count cannot overshoot the shorter limit
  assign expire_o    = (state_q == SLOT_ARMED) && tick_i && (cnt_q >= last)
                       && !release_req && !warm_rst_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (warm_rst_i || release_req) begin
      state_d = SLOT_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SLOT_IDLE: if (start_i) begin
          state_d = SLOT_ARMED;
          cnt_d   = '0;
        end
        SLOT_ARMED: if (tick_i) begin
          if (cnt_q >= last) state_d = SLOT_EXPIRED;
          else               cnt_d   = cnt_q + 1'b1;
        end
        SLOT_EXPIRED: ;
        default: state_d = SLOT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SLOT_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q == SLOT_ARMED);
  assign drop_o = (state_q == SLOT_EXPIRED);

  a_r1_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !release_req && !warm_rst_i) |=> (busy_o && $stable(cnt_q)))
    else $error("R1: armed slot moved without a tick");

  a_r4_hit_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> (!busy_o && !drop_o))
    else $error("R4: hit did not idle slot");

  a_r5_free_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |=> (!busy_o && !drop_o))
    else $error("R5: free did not idle slot");

  a_r6_drop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && !release_req && !warm_rst_i) |=> drop_o)
    else $error("R6: drop level lost");
endmodule

// File: rtl/drt_err_report.sv
module drt_err_report (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warm_rst_i,
  input  logic discard_i,
  input  logic err_en_i,
  input  logic fatal_sel_i,
  input  logic status_wr_i,
  input  logic status_wdata_i,
  output logic status_o,
  output logic fatal_err_o,
  output logic nonfatal_err_o
);
  logic status_q, fatal_q, nonfatal_q;
  logic report;

  assign report = discard_i && err_en_i && !warm_rst_i;

  // status is cold-reset only; set beats a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              status_q <= 1'b0;
    else if (discard_i)                       status_q <= 1'b1;
    else if (status_wr_i && status_wdata_i)   status_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fatal_q    <= 1'b0;
      nonfatal_q <= 1'b0;
    end else begin
      fatal_q    <= report && fatal_sel_i;
      nonfatal_q <= report && !fatal_sel_i;
    end
  end

  assign status_o       = status_q;
  assign fatal_err_o    = fatal_q;
  assign nonfatal_err_o = nonfatal_q;

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !(status_wr_i && status_wdata_i)) |=> status_o)
    else $error("R7: status dropped without a clearing write");

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_i |=> status_o)
    else $error("R7: discard did not set status");

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fatal_err_o && nonfatal_err_o))
    else $error("R8: both error outputs high");

  a_r8_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_en_i |=> (!fatal_err_o && !nonfatal_err_o))
    else $error("R8: error pulse while reporting disabled");
endmodule

// File: rtl/drt_discard_timer.sv
module drt_discard_timer #(
  parameter int NUM_SLOTS  = 4,
  parameter int LONG_LOG2  = 15,
  parameter int SHORT_LOG2 = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 warm_rst_i,
  input  logic                 tick_i,
  input  logic                 short_sel_i,
  input  logic                 err_en_i,
  input  logic                 fatal_sel_i,
  input  logic                 status_wr_i,
  input  logic                 status_wdata_i,
  input  logic [NUM_SLOTS-1:0] start_i,
  input  logic [NUM_SLOTS-1:0] hit_i,
  input  logic [NUM_SLOTS-1:0] free_i,
  output logic [NUM_SLOTS-1:0] busy_o,
  output logic [NUM_SLOTS-1:0] drop_o,
  output logic                 status_o,
  output logic                 fatal_err_o,
  output logic                 nonfatal_err_o
);
  logic [NUM_SLOTS-1:0] expire;
  logic                 any_discard;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    drt_slot_timer #(
      .LONG_LOG2 (LONG_LOG2),
      .SHORT_LOG2(SHORT_LOG2)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .warm_rst_i (warm_rst_i),
      .tick_i     (tick_i),
      .short_sel_i(short_sel_i),
      .start_i    (start_i[s]),
      .hit_i      (hit_i[s]),
      .free_i     (free_i[s]),
      .busy_o     (busy_o[s]),
      .drop_o     (drop_o[s]),
      .expire_o   (expire[s])
    );
  end

  // simultaneous expiries collapse to a single event
  assign any_discard = |expire;

  drt_err_report u_err (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .warm_rst_i    (warm_rst_i),
    .discard_i     (any_discard),
    .err_en_i      (err_en_i),
    .fatal_sel_i   (fatal_sel_i),
    .status_wr_i   (status_wr_i),
    .status_wdata_i(status_wdata_i),
    .status_o      (status_o),
    .fatal_err_o   (fatal_err_o),
    .nonfatal_err_o(nonfatal_err_o)
  );

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(expire) > 1 && err_en_i && !warm_rst_i) |=>
      $onehot({fatal_err_o, nonfatal_err_o}))
    else $error("R9: multi-slot discard gave bad pulse");

  a_r10_warm_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i && status_o && !(status_wr_i && status_wdata_i)) |=>
      (status_o && busy_o == '0 && drop_o == '0))
    else $error("R10: warm reset disturbed status or left a slot active");
endmodule

// File: tb/drt_discard_timer_tb.sv
module drt_discard_timer_tb;
  localparam int NS = 4;
  localparam int LL = 7;
  localparam int SL = 4;
  localparam int LONG_N  = 1 << LL;
  localparam int SHORT_N = 1 << SL;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic warm_rst_i = 1'b0, tick_i = 1'b1, short_sel_i = 1'b0;
  logic err_en_i = 1'b0, fatal_sel_i = 1'b0, status_wr_i = 1'b0, status_wdata_i = 1'b0;
  logic [NS-1:0] start_i = '0, hit_i = '0, free_i = '0;
  logic [NS-1:0] busy_o, drop_o;
  logic status_o, fatal_err_o, nonfatal_err_o;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  drt_discard_timer #(.NUM_SLOTS(NS), .LONG_LOG2(LL), .SHORT_LOG2(SL)) u_dut (
    .clk_i, .rst_ni, .warm_rst_i, .tick_i, .short_sel_i, .err_en_i, .fatal_sel_i,
    .status_wr_i, .status_wdata_i, .start_i, .hit_i, .free_i,
    .busy_o, .drop_o, .status_o, .fatal_err_o, .nonfatal_err_o
  );

  // {short_sel, err_en, fatal_sel, exp_drop, 4'b0, hit_at[7:0]}; hit_at 0 = none
  localparam logic [15:0] VEC [7] = '{
    {1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 8'd0},
    {1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 8'd0},
    {1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 8'd0},
    {1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 8'd16},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'd5},
    {1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 8'd0},
    {1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic arm(input logic [NS-1:0] m);
    start_i = m; cyc(); start_i = '0;
  endtask

  task automatic clear_status();
    status_wr_i = 1'b1; status_wdata_i = 1'b1; cyc();
    status_wr_i = 1'b0; status_wdata_i = 1'b0;
  endtask

  task automatic free_all();
    free_i = '1; cyc(); free_i = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) cyc();
    // R11 cold reset state
    chk("R11 busy", busy_o, 0);
    chk("R11 drop", drop_o, 0);
    chk("R11 status", status_o, 0);
    chk("R11 err", {fatal_err_o, nonfatal_err_o}, 0);
    rst_ni = 1'b1;
    cyc();

    // table: R2, R3, R4, R8
    for (int v = 0; v < 7; v++) begin
      automatic logic [15:0] e = VEC[v];
      automatic int lim = e[15] ? SHORT_N : LONG_N;
      automatic int hat = int'(e[7:0]);
      short_sel_i = e[15]; err_en_i = e[14]; fatal_sel_i = e[13];
      arm(4'b0001);
      chk("R1 armed", busy_o[0], 1);
      for (int i = 1; i <= lim; i++) begin
        if (i == hat) hit_i[0] = 1'b1;
        cyc();
        hit_i[0] = 1'b0;
        if (i == lim - 1 && hat == 0) chk(e[15] ? "R2 early" : "R3 early", drop_o[0], 0);
      end
      chk(e[15] ? "R2/R4 drop" : "R3/R4 drop", drop_o[0], e[12]);
      chk("R7 status set", status_o, e[12]);
      chk("R8 fatal", fatal_err_o, e[12] & e[14] & e[13]);
      chk("R8 nonfatal", nonfatal_err_o, e[12] & e[14] & ~e[13]);
      cyc();
      chk("R8 one cycle", {fatal_err_o, nonfatal_err_o}, 0);
      chk("R6 drop held", drop_o[0], e[12]);
      free_all();
      chk("R5 free from expired", drop_o[0], 0);
      clear_status();
    end

    // R1 tick gating
    short_sel_i = 1'b1; err_en_i = 1'b0;
    arm(4'b0010);
    repeat (8) cyc();
    tick_i = 1'b0; repeat (40) cyc();
    chk("R1 no count without tick", {busy_o[1], drop_o[1]}, 2'b10);
    tick_i = 1'b1; repeat (7) cyc();
    chk("R1 tick 15", drop_o[1], 0);
    cyc();
    chk("R1 tick 16", drop_o[1], 1);
    free_all(); clear_status();

    // R12 restart ignored
    arm(4'b0100);
    for (int i = 1; i <= SHORT_N; i++) begin
      if (i == 11) start_i[2] = 1'b1;
      cyc();
      start_i[2] = 1'b0;
      if (i == SHORT_N - 1) chk("R12 before", drop_o[2], 0);
    end
    chk("R12 restart ignored", drop_o[2], 1);
    free_all();

    // R7 write 0 no effect, write 1 clears
    chk("R7 status held", status_o, 1);
    status_wr_i = 1'b1; status_wdata_i = 1'b0; cyc(); status_wr_i = 1'b0;
    chk("R7 write0", status_o, 1);
    clear_status();
    chk("R7 write1", status_o, 0);

    // R7 discard beats same-edge clear
    arm(4'b0001);
    repeat (SHORT_N - 1) cyc();
    status_wr_i = 1'b1; status_wdata_i = 1'b1; cyc();
    status_wr_i = 1'b0; status_wdata_i = 1'b0;
    chk("R7 set wins", status_o, 1);
    free_all(); clear_status();

    // R5 free from armed
    arm(4'b1000);
    repeat (3) cyc();
    free_i[3] = 1'b1; cyc(); free_i[3] = 1'b0;
    chk("R5 freed", busy_o[3], 0);
    repeat (SHORT_N + 4) cyc();
    chk("R5 no later drop", {drop_o[3], status_o}, 0);

    // R9 two slots together
    err_en_i = 1'b1; fatal_sel_i = 1'b0;
    arm(4'b0110);
    repeat (SHORT_N) cyc();
    chk("R9 both drop", drop_o, 4'b0110);
    chk("R9 pulse", {fatal_err_o, nonfatal_err_o}, 2'b01);
    cyc();
    chk("R9 single pulse", {fatal_err_o, nonfatal_err_o}, 2'b00);
    free_all();

    // R10 warm reset keeps status
    arm(4'b1001);
    repeat (3) cyc();
    warm_rst_i = 1'b1; cyc(); warm_rst_i = 1'b0;
    chk("R10 slots idle", busy_o, 0);
    chk("R10 status kept", status_o, 1);
    repeat (SHORT_N + 2) cyc();
    chk("R10 no stale expiry", {drop_o, fatal_err_o, nonfatal_err_o}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule